// File: doc/BRIEF.md
# UART Register Bank with Interrupt Latching

This block is the software-facing register file of a simple serial port. A register port with valid, write, address and data lines reaches a set of 32-bit words. They hold the control settings, the status flags, the receive holding byte, the FIFO thresholds and a four-bit interrupt state. The transmit and receive datapaths sit beside it. The transmit side reports its fill level and its watermark and empty events. The receive side delivers bytes, one per pulse. In return the block issues push, pop and flush pulses. The serial line logic itself is not in this block. Noise filtering, parity and loopback bits are only stored in the control word.

Each of the four interrupt lines is the AND of a latched state bit and an enable bit. Software clears state bits by writing ones to the state word. A separate test word lets software raise state bits. A hardware event and a clearing write that meet the same bit in the same cycle leave the bit set. Reading the receive data word is not passive: it pops one entry from the receive count and moves the idle and empty flags.

Top module: `uart_regbank`

## Requirements
- R1: After reset the status word (offset 0x14) reads 0x3C, every other readable word reads 0, and all four interrupt lines are low.
- R2: Interrupt state bits are: bit 0 transmit watermark, bit 1 receive watermark, bit 2 transmit empty, bit 3 receive overflow. Each interrupt line is high exactly when its state bit and its enable bit (offset 0x04) are both 1. The `ev_tx_watermark` and `ev_tx_empty` pulses set state bits 0 and 2.
- R3: A write to the state word (offset 0x00) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R4: A write to the test word (offset 0x08) ORs the written low four bits into the state.
- R5: If a hardware set event and a clearing write hit the same state bit in the same cycle, the bit ends up set.
- R6: While receive is enabled (control bit 1), an `rx_valid` pulse loads `rx_byte` into the receive data word (offset 0x18), raises the receive level by one, and clears receive idle (status bit 4) and receive empty (status bit 5). While receive is disabled the pulse has no effect.
- R7: When an accepted byte leaves the receive level strictly above the threshold in FIFO control bits 4:2 (offset 0x20), state bit 1 is set.
- R8: A read of offset 0x18 returns the held byte. If receive is enabled and the level is nonzero, the read lowers the level by one and pulses `rx_pop` in the next cycle. A byte arriving in the same cycle as such a read leaves the level unchanged. Status bit 1 (receive full) is set only while the level equals the receive depth. Bits 4 and 5 are set only while the level is 0.
- R9: A byte arriving while the level equals the receive depth, with no pop in the same cycle, is dropped: the level and the held byte stay, and state bit 3 is set.
- R10: The FIFO status word (offset 0x24) holds the transmit level in bits 4:0 and the receive level in bits 20:16. Writing FIFO control with bit 0 set empties the receive level. Writing it with bit 1 set pulses `tx_fifo_clr` for one cycle.
- R11: The control word (offset 0x10) and the timeout word (offset 0x30) store all 32 bits. Control bit 0 drives `ctrl_tx_en`, bit 1 drives `ctrl_rx_en`, and bits 31:16 drive `baud_inc`. FIFO control bits 6:5 drive `tx_thresh`.
- R12: Writes to the status, receive data and FIFO status words have no effect. Reads of the test word, the transmit data word (0x1C), unmapped offsets and offsets not a multiple of 4 return 0. A write to an offset that is not a multiple of 4 changes nothing.
- R13: A write to offset 0x1C pulses `tx_push` for one cycle, with `tx_byte` set to write data bits 7:0. Status bit 0 is set when the sampled transmit level equals the transmit depth. Bits 2 and 3 are set when that level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Received byte pulse |
| rx_byte | input | 8 | Received byte |
| tx_level_in | input | TX_LVL_W | Transmit FIFO fill level |
| ev_tx_watermark | input | 1 | Transmit watermark event pulse |
| ev_tx_empty | input | 1 | Transmit empty event pulse |
| tx_push | output | 1 | Transmit byte push pulse |
| tx_byte | output | 8 | Byte to push |
| tx_fifo_clr | output | 1 | Transmit FIFO flush pulse |
| rx_pop | output | 1 | Receive FIFO pop pulse |
| ctrl_tx_en | output | 1 | Transmit enable |
| ctrl_rx_en | output | 1 | Receive enable |
| baud_inc | output | 16 | Baud increment value |
| tx_thresh | output | 2 | Transmit watermark threshold |
| irq_tx_watermark | output | 1 | Transmit watermark interrupt |
| irq_rx_watermark | output | 1 | Receive watermark interrupt |
| irq_tx_empty | output | 1 | Transmit empty interrupt |
| irq_rx_overflow | output | 1 | Receive overflow interrupt |

## Verification
Two pairs of actions can fall into one cycle. The first is a clearing write to the state word and a hardware set of the same bit. The second is a receive data read and an arriving byte. The bench holds both stimuli across the same clock edge. For the first pair it expects the bit to remain set. For the second it expects the read to return the previous byte, the level to stay put, and the new byte to be held afterwards. A separate case fills the receive count to its depth and offers one more byte, so the drop, the unchanged holding byte and the overflow bit can all be read back through the register port.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

  localparam int REG_W = 32;
  localparam int IRQ_N = 4;

  // interrupt bit positions (software decodes these)
  localparam int IRQ_TXWM  = 0;
  localparam int IRQ_RXWM  = 1;
  localparam int IRQ_TXEMP = 2;
  localparam int IRQ_RXOVF = 3;

  localparam logic [REG_W-1:0] OFS_ISTATE = 32'h00;
  localparam logic [REG_W-1:0] OFS_IEN    = 32'h04;
  localparam logic [REG_W-1:0] OFS_ITEST  = 32'h08;
  localparam logic [REG_W-1:0] OFS_CTRL   = 32'h10;
  localparam logic [REG_W-1:0] OFS_STATUS = 32'h14;
  localparam logic [REG_W-1:0] OFS_RDATA  = 32'h18;
  localparam logic [REG_W-1:0] OFS_WDATA  = 32'h1C;
  localparam logic [REG_W-1:0] OFS_FCTRL  = 32'h20;
  localparam logic [REG_W-1:0] OFS_FSTAT  = 32'h24;
  localparam logic [REG_W-1:0] OFS_TMO    = 32'h30;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ISTATE, SEL_IEN, SEL_ITEST, SEL_CTRL, SEL_STATUS,
    SEL_RDATA, SEL_WDATA, SEL_FCTRL, SEL_FSTAT, SEL_TMO
  } reg_sel_e;

  typedef struct packed {
    logic istate_wr;
    logic ien_wr;
    logic itest_wr;
    logic ctrl_wr;
    logic wdata_wr;
    logic fctrl_wr;
    logic tmo_wr;
    logic rdata_rd;
  } reg_stb_t;

  function automatic reg_sel_e offset_to_sel(input logic [REG_W-1:0] ofs);
    reg_sel_e s;
    s = SEL_NONE;
    if (ofs[1:0] == 2'b00) begin
      case (ofs)
        OFS_ISTATE: s = SEL_ISTATE;
        OFS_IEN:    s = SEL_IEN;
        OFS_ITEST:  s = SEL_ITEST;
        OFS_CTRL:   s = SEL_CTRL;
        OFS_STATUS: s = SEL_STATUS;
        OFS_RDATA:  s = SEL_RDATA;
        OFS_WDATA:  s = SEL_WDATA;
        OFS_FCTRL:  s = SEL_FCTRL;
        OFS_FSTAT:  s = SEL_FSTAT;
        OFS_TMO:    s = SEL_TMO;
        default:    s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

  // set events override the clear mask
  function automatic logic irq_bit_next(input logic cur, input logic clr,
                                        input logic tst, input logic set);
    return (cur & ~clr) | tst | set;
  endfunction

  function automatic logic [REG_W-1:0] fifo_status_word(input logic [4:0] tx_lvl,
                                                         input logic [4:0] rx_lvl);
    return {11'b0, rx_lvl, 11'b0, tx_lvl};
  endfunction

  function automatic logic [REG_W-1:0] status_word(input logic tx_full, input logic tx_empty,
                                                    input logic rx_full, input logic rx_empty);
    return {26'b0, rx_empty, rx_empty, tx_empty, tx_empty, rx_full, tx_full};
  endfunction

endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output reg_stb_t          stb
);

  always_comb begin
    sel = offset_to_sel(REG_W'(addr));
    stb = '0;
    if (valid && write) begin
      stb.istate_wr = (sel == SEL_ISTATE);
      stb.ien_wr    = (sel == SEL_IEN);
      stb.itest_wr  = (sel == SEL_ITEST);
      stb.ctrl_wr   = (sel == SEL_CTRL);
      stb.wdata_wr  = (sel == SEL_WDATA);
      stb.fctrl_wr  = (sel == SEL_FCTRL);
      stb.tmo_wr    = (sel == SEL_TMO);
    end
    if (valid && !write) begin
      stb.rdata_rd  = (sel == SEL_RDATA);
    end
  end

endmodule

// File: rtl/uart_reg_irq.sv
module uart_reg_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr,
  input  logic         clr_wr,
  input  logic         tst_wr,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] hw_set,
  output logic [N-1:0] state_o,
  output logic [N-1:0] enable_o,
  output logic [N-1:0] irq_o
);
  import uart_reg_pkg::irq_bit_next;

  logic [N-1:0] state_q;
  logic [N-1:0] enable_q;
  logic [N-1:0] clr_mask;
  logic [N-1:0] tst_mask;

  assign clr_mask = clr_wr ? wdata : '0;
  assign tst_mask = tst_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable_q <= '0;
    else if (en_wr) enable_q <= wdata;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q[i] <= 1'b0;
      else        state_q[i] <= irq_bit_next(state_q[i], clr_mask[i], tst_mask[i], hw_set[i]);
    end

    assign irq_o[i] = state_q[i] & enable_q[i];

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && wdata[i] && !tst_wr && !hw_set[i]) |=> !state_q[i]);
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[i] |=> state_q[i]);
    // R4
    test_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_wr && wdata[i]) |=> state_q[i]);
    // R2
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_wr && !tst_wr && !hw_set[i]) |=> $stable(state_q[i]));
  end

  assign state_o  = state_q;
  assign enable_o = enable_q;

endmodule

// File: rtl/uart_reg_rx.sv
module uart_reg_rx #(
  parameter int DEPTH  = 16,
  parameter int LVL_W  = $clog2(DEPTH + 1),
  parameter int THR_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [THR_W-1:0] thresh,
  input  logic             byte_valid,
  input  logic [7:0]       byte_in,
  input  logic             pop_req,
  input  logic             flush,
  output logic [LVL_W-1:0] level_o,
  output logic [7:0]       hold_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             pop_o,
  output logic             wm_set_o,
  output logic             ovf_set_o
);

  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

  logic [LVL_W-1:0] level_q;
  logic [LVL_W-1:0] level_after;
  logic [7:0]       hold_q;
  logic             pop_q;
  logic             at_max;
  logic             pop_fire;
  logic             accept;

  function automatic logic [LVL_W-1:0] step_level(input logic [LVL_W-1:0] cur,
                                                  input logic inc, input logic dec);
    return cur + LVL_W'(inc) - LVL_W'(dec);
  endfunction

  assign at_max      = (level_q == LVL_MAX);
  assign pop_fire    = pop_req && rx_en && (level_q != '0);
  assign accept      = byte_valid && rx_en && (!at_max || pop_fire);
  assign level_after = step_level(level_q, accept, pop_fire);
  assign wm_set_o    = accept && (level_after > LVL_W'(thresh));
  assign ovf_set_o   = byte_valid && rx_en && at_max && !pop_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      hold_q  <= '0;
      pop_q   <= 1'b0;
    end else begin
      level_q <= flush ? '0 : level_after;
      if (accept) hold_q <= byte_in;
      pop_q   <= pop_fire;
    end
  end

  assign level_o = level_q;
  assign hold_o  = hold_q;
  assign full_o  = at_max;
  assign empty_o = (level_q == '0);
  assign pop_o   = pop_q;

  // R8
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !accept && !flush) |=> (level_q == $past(level_q) - LVL_W'(1)));
  // R6
  push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pop_fire && !flush) |=> (level_q == $past(level_q) + LVL_W'(1)));
  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_MAX);
  // R9
  drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set_o && !flush) |=> (level_q == LVL_MAX && $stable(hold_q)));
  // R6
  disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !flush) |=> $stable(level_q));

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TX_LVL_W = $clog2(TX_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                rx_valid,
  input  logic [7:0]          rx_byte,
  input  logic [TX_LVL_W-1:0] tx_level_in,
  input  logic                ev_tx_watermark,
  input  logic                ev_tx_empty,
  output logic                tx_push,
  output logic [7:0]          tx_byte,
  output logic                tx_fifo_clr,
  output logic                rx_pop,
  output logic                ctrl_tx_en,
  output logic                ctrl_rx_en,
  output logic [15:0]         baud_inc,
  output logic [1:0]          tx_thresh,
  output logic                irq_tx_watermark,
  output logic                irq_rx_watermark,
  output logic                irq_tx_empty,
  output logic                irq_rx_overflow
);

  localparam int RX_LVL_W = $clog2(RX_DEPTH + 1);
  localparam int FCTRL_W  = 7;
  localparam logic [TX_LVL_W-1:0] TX_MAX = TX_LVL_W'(TX_DEPTH);

  reg_sel_e sel;
  reg_stb_t stb;

  logic [REG_W-1:0]    ctrl_q;
  logic [REG_W-1:0]    tmo_q;
  logic [FCTRL_W-1:0]  fctrl_q;
  logic [TX_LVL_W-1:0] tx_lvl_q;
  logic                tx_push_q;
  logic [7:0]          tx_byte_q;
  logic                tx_clr_q;

  logic [IRQ_N-1:0]    hw_set;
  logic [IRQ_N-1:0]    istate;
  logic [IRQ_N-1:0]    ienable;
  logic [IRQ_N-1:0]    irq_vec;

  logic [RX_LVL_W-1:0] rx_level;
  logic [7:0]          rx_hold;
  logic                rx_full;
  logic                rx_empty;
  logic                rx_wm_evt;
  logic                rx_ovf_evt;
  logic                rx_flush;

  uart_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid (bus_valid),
    .write (bus_write),
    .addr  (bus_addr),
    .sel   (sel),
    .stb   (stb)
  );

  assign rx_flush = stb.fctrl_wr && bus_wdata[0];

  uart_reg_rx #(.DEPTH(RX_DEPTH), .LVL_W(RX_LVL_W), .THR_W(3)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (ctrl_q[1]),
    .thresh     (fctrl_q[4:2]),
    .byte_valid (rx_valid),
    .byte_in    (rx_byte),
    .pop_req    (stb.rdata_rd),
    .flush      (rx_flush),
    .level_o    (rx_level),
    .hold_o     (rx_hold),
    .full_o     (rx_full),
    .empty_o    (rx_empty),
    .pop_o      (rx_pop),
    .wm_set_o   (rx_wm_evt),
    .ovf_set_o  (rx_ovf_evt)
  );

  always_comb begin
    hw_set            = '0;
    hw_set[IRQ_TXWM]  = ev_tx_watermark;
    hw_set[IRQ_RXWM]  = rx_wm_evt;
    hw_set[IRQ_TXEMP] = ev_tx_empty;
    hw_set[IRQ_RXOVF] = rx_ovf_evt;
  end

  uart_reg_irq #(.N(IRQ_N)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (stb.ien_wr),
    .clr_wr   (stb.istate_wr),
    .tst_wr   (stb.itest_wr),
    .wdata    (bus_wdata[IRQ_N-1:0]),
    .hw_set   (hw_set),
    .state_o  (istate),
    .enable_o (ienable),
    .irq_o    (irq_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      tmo_q     <= '0;
      fctrl_q   <= '0;
      tx_lvl_q  <= '0;
      tx_push_q <= 1'b0;
      tx_byte_q <= '0;
      tx_clr_q  <= 1'b0;
    end else begin
      if (stb.ctrl_wr)  ctrl_q  <= bus_wdata;
      if (stb.tmo_wr)   tmo_q   <= bus_wdata;
      if (stb.fctrl_wr) fctrl_q <= bus_wdata[FCTRL_W-1:0];
      tx_lvl_q  <= tx_level_in;
      tx_push_q <= stb.wdata_wr;
      if (stb.wdata_wr) tx_byte_q <= bus_wdata[7:0];
      tx_clr_q  <= stb.fctrl_wr && bus_wdata[1];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (sel)
        SEL_ISTATE: bus_rdata = REG_W'(istate);
        SEL_IEN:    bus_rdata = REG_W'(ienable);
        SEL_CTRL:   bus_rdata = ctrl_q;
        SEL_STATUS: bus_rdata = status_word(tx_lvl_q == TX_MAX, tx_lvl_q == '0,
                                            rx_full, rx_empty);
        SEL_RDATA:  bus_rdata = REG_W'(rx_hold);
        SEL_FCTRL:  bus_rdata = REG_W'(fctrl_q);
        SEL_FSTAT:  bus_rdata = fifo_status_word(5'(tx_lvl_q), 5'(rx_level));
        SEL_TMO:    bus_rdata = tmo_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign tx_push          = tx_push_q;
  assign tx_byte          = tx_byte_q;
  assign tx_fifo_clr      = tx_clr_q;
  assign ctrl_tx_en       = ctrl_q[0];
  assign ctrl_rx_en       = ctrl_q[1];
  assign baud_inc         = ctrl_q[31:16];
  assign tx_thresh        = fctrl_q[6:5];
  assign irq_tx_watermark = irq_vec[IRQ_TXWM];
  assign irq_rx_watermark = irq_vec[IRQ_RXWM];
  assign irq_tx_empty     = irq_vec[IRQ_TXEMP];
  assign irq_rx_overflow  = irq_vec[IRQ_RXOVF];

  // R13
  push_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> $past(bus_valid && bus_write));
  // R12
  ro_status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && sel == SEL_STATUS) |=> $stable(ctrl_q) && $stable(fctrl_q));
  // R2
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_vec) <= $countones(ienable));

endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [4:0]  tx_level_in = '0;
  logic        ev_tx_watermark = 1'b0;
  logic        ev_tx_empty = 1'b0;
  logic        tx_push, tx_fifo_clr, rx_pop, ctrl_tx_en, ctrl_rx_en;
  logic [7:0]  tx_byte;
  logic [15:0] baud_inc;
  logic [1:0]  tx_thresh;
  logic        irq_tx_watermark, irq_rx_watermark, irq_tx_empty, irq_rx_overflow;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_level_in(tx_level_in),
    .ev_tx_watermark(ev_tx_watermark), .ev_tx_empty(ev_tx_empty),
    .tx_push(tx_push), .tx_byte(tx_byte), .tx_fifo_clr(tx_fifo_clr),
    .rx_pop(rx_pop), .ctrl_tx_en(ctrl_tx_en), .ctrl_rx_en(ctrl_rx_en),
    .baud_inc(baud_inc), .tx_thresh(tx_thresh),
    .irq_tx_watermark(irq_tx_watermark), .irq_rx_watermark(irq_rx_watermark),
    .irq_tx_empty(irq_tx_empty), .irq_rx_overflow(irq_rx_overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(10'h14, v); chk("R1 status", v, 32'h3C);
    rd(10'h00, v); chk("R1 istate", v, 0);
    rd(10'h04, v); chk("R1 ienable", v, 0);
    rd(10'h10, v); chk("R1 ctrl", v, 0);
    rd(10'h24, v); chk("R1 fifo status", v, 0);
    rd(10'h30, v); chk("R1 timeout", v, 0);
    chk("R1 irqs", {irq_rx_overflow, irq_tx_empty, irq_rx_watermark, irq_tx_watermark}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(10'h10, 32'hABCD_00F3);
    rd(10'h10, v); chk("R11 ctrl readback", v, 32'hABCD_00F3);
    chk("R11 outputs", {ctrl_tx_en, ctrl_rx_en, baud_inc}, {2'b11, 16'hABCD});
    wr(10'h30, 32'h1234_5678);
    rd(10'h30, v); chk("R11 timeout readback", v, 32'h1234_5678);
    wr(10'h20, 32'h40);
    chk("R11 tx_thresh", tx_thresh, 2'b10);
    wr(10'h20, 32'h0);
    wr(10'h10, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(10'h04, 32'hF);
    wr(10'h08, 32'h5);
    rd(10'h00, v); chk("R4 test or", v, 32'h5);
    chk("R2 lines", {irq_rx_overflow, irq_tx_empty, irq_rx_watermark, irq_tx_watermark}, 4'b0101);
    wr(10'h04, 32'h1);
    chk("R2 masked", {irq_rx_overflow, irq_tx_empty, irq_rx_watermark, irq_tx_watermark}, 4'b0001);
    wr(10'h00, 32'h1);
    rd(10'h00, v); chk("R3 w1c", v, 32'h4);
    wr(10'h00, 32'h4);
    @(negedge clk); ev_tx_empty = 1'b1; @(negedge clk); ev_tx_empty = 1'b0;
    rd(10'h00, v); chk("R2 hw event bit2", v, 32'h4);
    // R5: clear write and set event in the same cycle
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 10'h00; bus_wdata = 32'h5;
    ev_tx_empty = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; ev_tx_empty = 1'b0;
    rd(10'h00, v); chk("R5 set wins", v, 32'h4);
    @(negedge clk); ev_tx_watermark = 1'b1; @(negedge clk); ev_tx_watermark = 1'b0;
    chk("R2 txwm line", irq_tx_watermark, 1'b1);
    wr(10'h00, 32'hF);
    wr(10'h04, 32'hF);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    wr(10'h10, 32'h2);
    wr(10'h20, 32'h08);          // receive threshold 2
    push_byte(8'h11);
    rd(10'h14, v); chk("R6 flags cleared", v, 32'h0C);
    rd(10'h00, v); chk("R7 below threshold", v, 0);
    push_byte(8'h22);
    push_byte(8'h33);
    rd(10'h00, v); chk("R7 watermark set", v, 32'h2);
    chk("R2 rxwm line", irq_rx_watermark, 1'b1);
    rd(10'h24, v); chk("R10 rx level field", v, 32'h0003_0000);
    rd(10'h18, v); chk("R8 read byte", v, 32'h33);
    chk("R8 pop pulse", rx_pop, 1'b1);
    @(negedge clk); chk("R8 pop one cycle", rx_pop, 1'b0);
    rd(10'h24, v); chk("R8 level dec", v, 32'h0002_0000);
    // R8: read and arrival in one cycle
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 10'h18;
    rx_valid = 1'b1; rx_byte = 8'h44;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0; rx_valid = 1'b0;
    chk("R8 same-cycle old byte", v, 32'h33);
    rd(10'h24, v); chk("R8 same-cycle level", v, 32'h0002_0000);
    rd(10'h18, v); chk("R8 new byte held", v, 32'h44);
    rd(10'h18, v);
    rd(10'h14, v); chk("R8 empty idle back", v, 32'h3C);
    rd(10'h18, v); chk("R8 no pop at zero", rx_pop, 1'b0);
    rd(10'h24, v); chk("R8 level stays zero", v, 0);
    wr(10'h00, 32'hF);
    wr(10'h10, 32'h0);
    push_byte(8'h99);
    rd(10'h24, v); chk("R6 disabled ignored", v, 0);
    rd(10'h18, v); chk("R6 disabled hold", v, 32'h44);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(10'h10, 32'h2);
    wr(10'h20, 32'h1C);          // threshold 7
    for (int i = 0; i < DEPTH; i++) push_byte(8'(8'h40 + i));
    rd(10'h14, v); chk("R8 full flag", v, 32'h0E);
    wr(10'h00, 32'hF);
    push_byte(8'hEE);
    rd(10'h00, v); chk("R9 overflow bit", v, 32'h8);
    chk("R9 overflow line", irq_rx_overflow, 1'b1);
    rd(10'h24, v); chk("R9 level kept", v, 32'h0010_0000);
    rd(10'h18, v); chk("R9 byte dropped", v, 32'h4F);
    wr(10'h20, 32'h1);
    rd(10'h24, v); chk("R10 rx flush", v, 0);
    wr(10'h00, 32'hF);
    wr(10'h10, 32'h0);
  endtask

  task automatic t_tx();
    logic [31:0] v;
    wr(10'h1C, 32'h1A5);
    chk("R13 push pulse", {tx_push, tx_byte}, {1'b1, 8'hA5});
    @(negedge clk); chk("R13 push one cycle", tx_push, 1'b0);
    @(negedge clk); tx_level_in = 5'd16;
    @(negedge clk);
    rd(10'h14, v); chk("R13 tx full", v, 32'h31);
    rd(10'h24, v); chk("R10 tx level field", v, 32'h10);
    tx_level_in = 5'd3;
    @(negedge clk);
    rd(10'h14, v); chk("R13 tx partial", v, 32'h30);
    tx_level_in = 5'd0;
    wr(10'h20, 32'h2);
    chk("R10 tx flush pulse", tx_fifo_clr, 1'b1);
    @(negedge clk); chk("R10 tx flush one cycle", tx_fifo_clr, 1'b0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(10'h14, 32'hFFFF_FFFF);
    rd(10'h14, v); chk("R12 status ro", v, 32'h3C);
    wr(10'h24, 32'hFFFF_FFFF);
    rd(10'h24, v); chk("R12 fifo status ro", v, 0);
    wr(10'h10, 32'h2);
    push_byte(8'h5A);
    wr(10'h18, 32'hFF);
    rd(10'h18, v); chk("R12 rdata ro", v, 32'h5A);
    rd(10'h08, v); chk("R12 test reads 0", v, 0);
    rd(10'h1C, v); chk("R12 wdata reads 0", v, 0);
    rd(10'h2C, v); chk("R12 unmapped 0", v, 0);
    rd(10'h3FC, v); chk("R12 top unmapped 0", v, 0);
    rd(10'h11, v); chk("R12 misaligned read", v, 0);
    wr(10'h11, 32'hFFFF_FFFF);
    rd(10'h10, v); chk("R12 misaligned write", v, 32'h2);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_err++;
    $display("FAIL watchdog R1-all actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_irq();
    t_rx();
    t_overflow();
    t_tx();
    t_map();
    finish_run();
  end

endmodule